// File: doc/BRIEF.md
# Arbitrated System Bus Hub

This block is the shared bus of a small subsystem. Two masters contend for it: a processor master and an I/O master that can also move data straight into or out of memory without the processor. Two targets hang off it: a word-addressed memory and a bank of I/O port registers. A master asks for the bus with a request line and may present a command only while it holds the grant. One command strobe is raised per transfer, for one cycle. The target finishes the transfer with an acknowledge pulse, or the bus raises an error pulse if the command does not match the address region.

The top address bit chooses the target. When it is 0, the remaining bits index a memory word. When it is 1, the low bits index an I/O port. The block also carries the interrupt handshake between the I/O side and the processor. A pending flag is set by the I/O side's request and cleared when the processor acknowledges it. Only an acknowledge that meets a pending request is passed back to the I/O side.

Top module: `bus_hub`

## Requirements
- R1: A master that raises its request while the bus is idle sees its grant high in the next cycle. No grant rises without a request from that master in the previous cycle.
- R2: At most one grant is high at a time. When both masters request in the same idle cycle, the I/O master is granted.
- R3: A grant stays high until the cycle of its transfer's acknowledge or error, and the other master's request cannot take it away. It drops after that cycle, or one cycle after the owner lowers its request before issuing a command.
- R4: Address bit 7 = 0 selects memory word addr[6:0]. Address bit 7 = 1 selects I/O port addr[1:0] when there are 4 ports, so port addresses alias modulo the port count.
- R5: Command bit 0 is memory write and bit 1 is memory read. A legal memory command is acknowledged with a one-cycle busAck in the cycle after the command. A read returns the addressed word on busRdata in that cycle.
- R6: Command bit 2 is I/O write and bit 3 is I/O read. A legal I/O command is acknowledged two cycles after the command. A read returns the addressed port value with the acknowledge.
- R7: A memory command to an address at or above 0x80, or an I/O command to an address below 0x80, raises busErr for one cycle in the next cycle. It gets no busAck and changes no storage.
- R8: A command vector that has no bit set, or more than one bit set, is ignored. There is no ack and no error, the grant is kept, and storage is unchanged.
- R9: The I/O master can write and read memory itself. Data it writes is read back identically by the processor master.
- R10: A cycle with ioIrqReq high makes cpuIrq high from the next cycle on. cpuIrq stays high until a cycle with cpuIntAck high and no new request. A new request in the same cycle as the acknowledge keeps it pending.
- R11: ioIntAck is high exactly in cycles where cpuIntAck is high while an interrupt is pending. An acknowledge with nothing pending is not forwarded.
- R12: After reset both grants, busAck, busErr, busRdata, cpuIrq and every I/O port read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor master bus request |
| cpuCmd | input | 4 | Processor command strobes (bit0 mem wr, bit1 mem rd, bit2 io wr, bit3 io rd) |
| cpuAddr | input | ADDR_W | Processor address |
| cpuWdata | input | DATA_W | Processor write data |
| cpuGnt | output | 1 | Bus granted to processor master |
| dmaReq | input | 1 | I/O master bus request |
| dmaCmd | input | 4 | I/O master command strobes, same encoding |
| dmaAddr | input | ADDR_W | I/O master address |
| dmaWdata | input | DATA_W | I/O master write data |
| dmaGnt | output | 1 | Bus granted to I/O master |
| busRdata | output | DATA_W | Read data, valid with busAck |
| busAck | output | 1 | Transfer acknowledge pulse |
| busErr | output | 1 | Region-mismatch error pulse |
| ioIrqReq | input | 1 | Interrupt request from the I/O side |
| cpuIrq | output | 1 | Pending interrupt toward the processor |
| cpuIntAck | input | 1 | Interrupt acknowledge from the processor |
| ioIntAck | output | 1 | Acknowledge forwarded to the I/O side |

## Verification
Two pairs of functions can fall in the same cycle. Two requests can arrive in one idle cycle, and an interrupt request can coincide with its acknowledge. The bench raises both bus requests on the same clock edge and expects the I/O master to win. It then expects the processor's grant to stay low through the whole I/O transfer and to rise only after the release cycle. For the interrupt, it drives ioIrqReq and cpuIntAck together while a request is already pending, and expects cpuIrq to remain set. It runs the same handshake in the middle of random bus traffic and checks that the transfers are unaffected.

// File: rtl/bus_hub_pkg.sv
package bus_hub_pkg;
  localparam int CMD_W      = 4;
  localparam int CMD_MEM_WR = 0;
  localparam int CMD_MEM_RD = 1;
  localparam int CMD_IO_WR  = 2;
  localparam int CMD_IO_RD  = 3;

  typedef struct packed {
    logic memWe;
    logic memRe;
    logic ioWe;
    logic ioRe;
    logic useDma;
  } dpCtrl_t;
endpackage

// File: rtl/bus_hub_ctrl.sv
module bus_hub_ctrl
  import bus_hub_pkg::*;
#(
  parameter int MEM_LAT = 1,
  parameter int IO_LAT  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             dmaReq,
  input  logic [CMD_W-1:0] cpuCmd,
  input  logic [CMD_W-1:0] dmaCmd,
  input  logic             cpuHi,
  input  logic             dmaHi,
  output dpCtrl_t          dpCtl,
  output logic             cpuGnt,
  output logic             dmaGnt,
  output logic             busAck,
  output logic             busErr
);
  localparam int MAX_LAT = (MEM_LAT > IO_LAT) ? MEM_LAT : IO_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_OWN, ST_WAIT, ST_ERR} state_t;

  state_t           stQ;
  logic             ownerQ;
  logic [CNT_W-1:0] cntQ;

  logic [CMD_W-1:0] cmdSel;
  logic             hiSel, reqSel, isMem, legal, fire;

  always_comb begin
    cmdSel = ownerQ ? dmaCmd : cpuCmd;
    hiSel  = ownerQ ? dmaHi  : cpuHi;
    reqSel = ownerQ ? dmaReq : cpuReq;
    isMem  = cmdSel[CMD_MEM_WR] | cmdSel[CMD_MEM_RD];
    legal  = isMem ? !hiSel : hiSel;
    fire   = (stQ == ST_OWN) && reqSel && $onehot(cmdSel);
    dpCtl.memWe  = fire && legal && cmdSel[CMD_MEM_WR];
    dpCtl.memRe  = fire && legal && cmdSel[CMD_MEM_RD];
    dpCtl.ioWe   = fire && legal && cmdSel[CMD_IO_WR];
    dpCtl.ioRe   = fire && legal && cmdSel[CMD_IO_RD];
    dpCtl.useDma = ownerQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ    <= ST_IDLE;
      ownerQ <= 1'b0;
      cntQ   <= '0;
    end else begin
      case (stQ)
        ST_IDLE: begin
          if (dmaReq) begin
            stQ    <= ST_OWN;
            ownerQ <= 1'b1;
          end else if (cpuReq) begin
            stQ    <= ST_OWN;
            ownerQ <= 1'b0;
          end
        end
        ST_OWN: begin
          if (!reqSel) begin
            stQ <= ST_IDLE;
          end else if (fire) begin
            if (legal) begin
              stQ  <= ST_WAIT;
              cntQ <= isMem ? CNT_W'(MEM_LAT) : CNT_W'(IO_LAT);
            end else begin
              stQ <= ST_ERR;
            end
          end
        end
        ST_WAIT: begin
          if (cntQ == CNT_W'(1)) stQ <= ST_IDLE;
          else cntQ <= cntQ - 1'b1;
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end

  assign busAck = (stQ == ST_WAIT) && (cntQ == CNT_W'(1));
  assign busErr = (stQ == ST_ERR);
  assign cpuGnt = (stQ != ST_IDLE) && !ownerQ;
  assign dmaGnt = (stQ != ST_IDLE) && ownerQ;
endmodule

// File: rtl/bus_hub_dp.sv
module bus_hub_dp
  import bus_hub_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] dmaAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] dmaWdata,
  output logic [DATA_W-1:0] busRdata
);
  localparam int MEM_AW    = ADDR_W - 1;
  localparam int MEM_WORDS = 2 ** MEM_AW;
  localparam int PORT_AW   = $clog2(NUM_PORTS);

  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  wdata;
  logic [MEM_AW-1:0]  memIdx;
  logic [PORT_AW-1:0] portIdx;
  logic [DATA_W-1:0]  memQ  [MEM_WORDS];
  logic [DATA_W-1:0]  portQ [NUM_PORTS];
  logic [NUM_PORTS-1:0] portWe;

  assign addr    = dpCtl.useDma ? dmaAddr  : cpuAddr;
  assign wdata   = dpCtl.useDma ? dmaWdata : cpuWdata;
  assign memIdx  = addr[MEM_AW-1:0];
  assign portIdx = addr[PORT_AW-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_portWe
    assign portWe[p] = dpCtl.ioWe && (portIdx == PORT_AW'(p));
  end

  always_ff @(posedge clk) begin
    if (dpCtl.memWe) memQ[memIdx] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PORTS; p++) portQ[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (portWe[p]) portQ[p] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             busRdata <= '0;
    else if (dpCtl.memRe)  busRdata <= memQ[memIdx];
    else if (dpCtl.ioRe)   busRdata <= portQ[portIdx];
  end
endmodule

// File: rtl/bus_hub_irq.sv
module bus_hub_irq (
  input  logic clk,
  input  logic rstN,
  input  logic ioIrqReq,
  input  logic cpuIntAck,
  output logic cpuIrq,
  output logic ioIntAck
);
  logic pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pendQ <= 1'b0;
    else if (ioIrqReq)  pendQ <= 1'b1;
    else if (cpuIntAck) pendQ <= 1'b0;
  end

  assign cpuIrq   = pendQ;
  assign ioIntAck = cpuIntAck && pendQ;
endmodule

// File: rtl/bus_hub.sv
module bus_hub
  import bus_hub_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 4,
  parameter int MEM_LAT   = 1,
  parameter int IO_LAT    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic [CMD_W-1:0]  cpuCmd,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuGnt,
  input  logic              dmaReq,
  input  logic [CMD_W-1:0]  dmaCmd,
  input  logic [ADDR_W-1:0] dmaAddr,
  input  logic [DATA_W-1:0] dmaWdata,
  output logic              dmaGnt,
  output logic [DATA_W-1:0] busRdata,
  output logic              busAck,
  output logic              busErr,
  input  logic              ioIrqReq,
  output logic              cpuIrq,
  input  logic              cpuIntAck,
  output logic              ioIntAck
);
  dpCtrl_t dpCtl;

  bus_hub_ctrl #(.MEM_LAT(MEM_LAT), .IO_LAT(IO_LAT)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .dmaReq(dmaReq),
    .cpuCmd(cpuCmd), .dmaCmd(dmaCmd),
    .cpuHi(cpuAddr[ADDR_W-1]), .dmaHi(dmaAddr[ADDR_W-1]),
    .dpCtl(dpCtl),
    .cpuGnt(cpuGnt), .dmaGnt(dmaGnt),
    .busAck(busAck), .busErr(busErr)
  );

  bus_hub_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .cpuAddr(cpuAddr), .dmaAddr(dmaAddr),
    .cpuWdata(cpuWdata), .dmaWdata(dmaWdata),
    .busRdata(busRdata)
  );

  bus_hub_irq irq_i (
    .clk(clk), .rstN(rstN),
    .ioIrqReq(ioIrqReq), .cpuIntAck(cpuIntAck),
    .cpuIrq(cpuIrq), .ioIntAck(ioIntAck)
  );
endmodule

// File: rtl/bus_hub_chk.sv
module bus_hub_chk (
  input logic clk,
  input logic rstN,
  input logic cpuReq,
  input logic dmaReq,
  input logic cpuGnt,
  input logic dmaGnt,
  input logic busAck,
  input logic busErr,
  input logic ioIrqReq,
  input logic cpuIrq,
  input logic cpuIntAck,
  input logic ioIntAck
);
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuGnt && dmaGnt));
  a_r1_dma_gnt_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaGnt) |-> $past(dmaReq));
  a_r2_cpu_yields: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuGnt) |-> ($past(cpuReq) && !$past(dmaReq)));
  a_r3_cpu_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cpuGnt && cpuReq && !busAck && !busErr) |=> cpuGnt);
  a_r3_dma_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dmaGnt && dmaReq && !busAck && !busErr) |=> dmaGnt);
  a_r3_release: assert property (@(posedge clk) disable iff (!rstN)
    (busAck || busErr) |=> (!cpuGnt && !dmaGnt));
  a_r5_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);
  a_r7_no_ack_on_err: assert property (@(posedge clk) disable iff (!rstN)
    !(busAck && busErr));
  a_r10_irq_set: assert property (@(posedge clk) disable iff (!rstN)
    ioIrqReq |=> cpuIrq);
  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq && !cpuIntAck) |=> cpuIrq);
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ioIntAck && !ioIrqReq) |=> !cpuIrq);
endmodule

bind bus_hub bus_hub_chk chk_i (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .dmaReq(dmaReq),
  .cpuGnt(cpuGnt), .dmaGnt(dmaGnt), .busAck(busAck), .busErr(busErr),
  .ioIrqReq(ioIrqReq), .cpuIrq(cpuIrq), .cpuIntAck(cpuIntAck), .ioIntAck(ioIntAck)
);

// File: tb/bus_hub_tb_top.sv
`timescale 1ns/1ps
module bus_hub_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int NPORT  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, dmaReq = 1'b0;
  logic [3:0] cpuCmd = '0, dmaCmd = '0;
  logic [ADDR_W-1:0] cpuAddr = '0, dmaAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0, dmaWdata = '0;
  logic cpuGnt, dmaGnt, busAck, busErr;
  logic [DATA_W-1:0] busRdata;
  logic ioIrqReq = 1'b0, cpuIntAck = 1'b0;
  logic cpuIrq, ioIntAck;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] memModel [128];
  logic [DATA_W-1:0] portModel [NPORT];

  always #4 clk = ~clk;

  bus_hub dut_i (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuCmd(cpuCmd), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuGnt(cpuGnt),
    .dmaReq(dmaReq), .dmaCmd(dmaCmd), .dmaAddr(dmaAddr), .dmaWdata(dmaWdata), .dmaGnt(dmaGnt),
    .busRdata(busRdata), .busAck(busAck), .busErr(busErr),
    .ioIrqReq(ioIrqReq), .cpuIrq(cpuIrq), .cpuIntAck(cpuIntAck), .ioIntAck(ioIntAck)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // 0 ignored, 1 memory ack, 2 io ack, 3 region error
  function automatic int classify(input logic [3:0] cmd, input logic [7:0] addr);
    if (!$onehot(cmd)) return 0;
    if (cmd[0] || cmd[1]) return addr[7] ? 3 : 1;
    return addr[7] ? 2 : 3;
  endfunction

  task automatic xfer(input bit viaDma, input logic [3:0] cmd, input logic [7:0] addr,
                      input logic [7:0] wd, output logic [7:0] rd);
    int kind, lat;
    string tag;
    kind = classify(cmd, addr);
    lat  = (kind == 2 || kind == 0) ? 2 : 1;
    tag  = (kind == 1) ? "R5" : (kind == 2) ? "R6" : (kind == 3) ? "R7" : "R8";
    rd = '0;
    if (viaDma) dmaReq = 1'b1; else cpuReq = 1'b1;
    @(negedge clk);
    chk("R1 own grant", viaDma ? dmaGnt : cpuGnt, 1);
    chk("R2 other grant", viaDma ? cpuGnt : dmaGnt, 0);
    if (viaDma) begin dmaCmd = cmd; dmaAddr = addr; dmaWdata = wd; end
    else begin cpuCmd = cmd; cpuAddr = addr; cpuWdata = wd; end
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      cpuCmd = '0; dmaCmd = '0;
      chk({tag, " ack"}, busAck, (kind == 1 && c == 1) || (kind == 2 && c == 2));
      chk({tag, " err"}, busErr, (kind == 3 && c == 1));
      chk("R3 grant held", viaDma ? dmaGnt : cpuGnt, 1);
      if (busAck) rd = busRdata;
    end
    if (kind == 1 && cmd[1]) chk("R5 mem rdata", rd, memModel[addr[6:0]]);
    if (kind == 2 && cmd[3]) chk("R6 io rdata", rd, portModel[addr[1:0]]);
    if (kind == 1 && cmd[0]) memModel[addr[6:0]] = wd;
    if (kind == 2 && cmd[2]) portModel[addr[1:0]] = wd;
    cpuReq = 1'b0; dmaReq = 1'b0;
    @(negedge clk);
    chk("R3 released", {30'd0, cpuGnt, dmaGnt}, 0);
    chk("R5 ack single", busAck, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 bus never went idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h1d5e_a2b1));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 grants", {30'd0, cpuGnt, dmaGnt}, 0);
    chk("R12 ack/err", {30'd0, busAck, busErr}, 0);
    chk("R12 rdata", busRdata, 0);
    chk("R12 irq", cpuIrq, 0);
    for (int p = 0; p < NPORT; p++) begin
      portModel[p] = '0;
      xfer(1'b0, 4'b1000, 8'h80 + 8'(p), 8'h00, rd);
      chk("R12 port zero", rd, 0);
    end

    // fill memory (R5)
    for (int a = 0; a < 128; a++) xfer(1'b0, 4'b0001, 8'(a), 8'(a * 37 + 5), rd);

    // R4 port aliasing
    xfer(1'b0, 4'b0100, 8'h85, 8'h5a, rd);
    xfer(1'b1, 4'b1000, 8'hf1, 8'h00, rd);
    chk("R4 port alias", rd, 8'h5a);

    // R2/R3 collision: both request in the same idle cycle
    cpuReq = 1'b1; dmaReq = 1'b1;
    @(negedge clk);
    chk("R2 dma wins", dmaGnt, 1);
    chk("R2 cpu waits", cpuGnt, 0);
    dmaCmd = 4'b0001; dmaAddr = 8'h33; dmaWdata = 8'hc3;
    @(negedge clk);
    dmaCmd = '0;
    chk("R9 dma mem ack", busAck, 1);
    chk("R3 no preempt", cpuGnt, 0);
    memModel[8'h33] = 8'hc3;
    dmaReq = 1'b0;
    @(negedge clk);
    chk("R3 released after ack", {30'd0, cpuGnt, dmaGnt}, 0);
    @(negedge clk);
    chk("R1 cpu granted later", cpuGnt, 1);
    cpuReq = 1'b0;
    @(negedge clk);
    chk("R3 release on drop", cpuGnt, 0);
    xfer(1'b0, 4'b0010, 8'h33, 8'h00, rd);
    chk("R9 dma data seen by cpu", rd, 8'hc3);
    xfer(1'b1, 4'b0010, 8'h10, 8'h00, rd);
    chk("R9 dma reads memory", rd, memModel[8'h10]);

    // R7 / R8 directed
    xfer(1'b0, 4'b0001, 8'h80, 8'hee, rd);
    xfer(1'b1, 4'b0100, 8'h7f, 8'hee, rd);
    xfer(1'b0, 4'b0011, 8'h01, 8'hee, rd);
    xfer(1'b0, 4'b0000, 8'h02, 8'hee, rd);
    xfer(1'b0, 4'b0010, 8'h00, 8'h00, rd);
    chk("R7 error left memory", rd, memModel[0]);
    xfer(1'b0, 4'b0010, 8'h01, 8'h00, rd);
    chk("R8 ignored left memory", rd, memModel[1]);

    // R10 / R11 interrupt handshake
    cpuIntAck = 1'b1;
    #1 chk("R11 ack not forwarded idle", ioIntAck, 0);
    @(negedge clk);
    cpuIntAck = 1'b0;
    ioIrqReq = 1'b1;
    @(negedge clk);
    ioIrqReq = 1'b0;
    chk("R10 irq set", cpuIrq, 1);
    repeat (3) @(negedge clk);
    chk("R10 irq held", cpuIrq, 1);
    ioIrqReq = 1'b1; cpuIntAck = 1'b1;
    #1 chk("R11 ack forwarded", ioIntAck, 1);
    @(negedge clk);
    ioIrqReq = 1'b0; cpuIntAck = 1'b0;
    chk("R10 new req beats ack", cpuIrq, 1);
    cpuIntAck = 1'b1;
    @(negedge clk);
    cpuIntAck = 1'b0;
    chk("R10 ack clears", cpuIrq, 0);

    // random traffic with an interrupt running in the background
    for (int i = 0; i < 300; i++) begin
      int sel;
      logic [3:0] cmd;
      logic [7:0] addr;
      bit viaDma;
      viaDma = 1'($urandom % 2);
      sel = int'($urandom % 10);
      addr = 8'($urandom);
      case (sel)
        0, 1: begin cmd = 4'b0001; addr[7] = 1'b0; end
        2, 3: begin cmd = 4'b0010; addr[7] = 1'b0; end
        4:    begin cmd = 4'b0100; addr[7] = 1'b1; end
        5, 6: begin cmd = 4'b1000; addr[7] = 1'b1; end
        7:    begin cmd = 4'b0001 << ($urandom % 4); addr[7] = cmd[0] | cmd[1]; end
        8:    cmd = 4'b0101 << ($urandom % 2);
        default: cmd = 4'b0000;
      endcase
      if (i == 150) ioIrqReq = 1'b1;
      xfer(viaDma, cmd, addr, 8'($urandom), rd);
      if (i == 150) begin
        ioIrqReq = 1'b0;
        chk("R10 irq during traffic", cpuIrq, 1);
        cpuIntAck = 1'b1;
        #1 chk("R11 ack during traffic", ioIntAck, 1);
        @(negedge clk);
        cpuIntAck = 1'b0;
        chk("R10 cleared during traffic", cpuIrq, 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule